// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block holds the floating-point status and control word of a processor core. It stores sticky exception flags, exception enable bits, a few result-information bits and a two-bit rounding-mode field. Software-style commands change it in three ways: set one bit chosen by a 5-bit index, clear one bit chosen by the same index, or replace the whole word. The arithmetic unit adds new exception flags through an event input. The flags are OR-ed in, so none is ever lost.

Two bits of the word are summaries and have no storage of their own. The invalid-operation summary is the OR of the nine invalid-operation flags. The enabled-exception summary is the OR of each exception flag AND-ed with its enable. Both are derived from the stored bits in the same cycle the stored bits change. No command can force either one, and neither can stay at 1 after the flags beneath it are cleared. The block outputs the full word, the rounding mode for the arithmetic unit, and an interrupt request that follows the enabled-exception summary.

Bits are numbered from the most significant end. Bit number n sits at bit position 31−n of the 32-bit word.

Top module: `fpu_stat_reg`

## Requirements
- R1: While reset is low, and after it is released, the word reads 0, the rounding mode reads 0 and the interrupt request is low.
- R2: Bit 2 (the invalid-operation summary) reads as the OR of the invalid flags at bit numbers 7, 8, 9, 10, 11, 12, 21, 22 and 23.
- R3: Bit 1 (the enabled-exception summary) reads as the OR of five terms, each an AND of a flag and its enable. The pairs are bit 2 with bit 24, bit 3 with bit 25, bit 4 with bit 26, bit 5 with bit 27, and bit 6 with bit 28.
- R4: Set, clear and full-word writes have no effect on bit 1 or bit 2; those bits always show their computed values. Bit 20 is reserved and always reads 0.
- R5: Set and clear use one shared 5-bit index. Index n addresses word position 31−n. A full-word write has priority over a clear, and a clear has priority over a set. Each command takes effect at the next clock edge.
- R6: An event ORs the event vector into the sticky flags in the same cycle as any software command, after that command. The sticky flags are bit numbers 3 to 12 and 21 to 23. Event bits at any other position are ignored.
- R7: Bit 0 (exception seen) becomes 1 whenever any sticky flag goes from 0 to 1. Only a clear or a full-word write can bring it back to 0.
- R8: The rounding-mode output is {bit 30, bit 31}. A set, clear or write aimed at those bits changes the output one cycle later.
- R9: The interrupt request equals the enabled-exception summary in every cycle.
- R10: In the cycle a clear removes the last flag or enable behind a summary, that summary reads 0, and so does any enabled-exception term that depended on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write the whole word |
| wr_data | input | 32 | Word value for a write |
| set_en | input | 1 | Set the indexed bit |
| clr_en | input | 1 | Clear the indexed bit |
| bit_idx | input | 5 | Bit number for set and clear |
| evt_en | input | 1 | Exception event from the arithmetic unit |
| evt_flags | input | 32 | Flags to OR into the sticky bits |
| stat_word | output | 32 | Register value with the summaries included |
| rmode | output | 2 | Current rounding mode |
| exc_irq | output | 1 | Enabled-exception interrupt request |

## Verification
The software commands and the event input can act in the same cycle. The most delicate case is a clear aimed at a flag that an event raises on the same edge. The bench drives that collision directly and expects the flag to survive and the exception-seen bit to rise. It also drives set, clear and write together on one index to judge the priority order. A long random mix of all four inputs is compared against a bench model in every cycle, so that summary drift after any interleaving is detected.

// File: rtl/fpu_stat_pkg.sv
package fpu_stat_pkg;

   localparam int unsigned FS_W    = 32;
   localparam int unsigned FS_IDX  = 5;
   localparam int unsigned RM_W    = 2;
   localparam int unsigned N_INV   = 9;
   localparam int unsigned N_PAIR  = 5;

   typedef logic [FS_W-1:0] fs_word_t;

   // bit numbers, counted from the most significant end
   localparam int unsigned B_SEEN    = 0;
   localparam int unsigned B_EN_SUM  = 1;
   localparam int unsigned B_INV_SUM = 2;
   localparam int unsigned B_RSV     = 20;
   localparam int unsigned B_RM_HI   = 30;
   localparam int unsigned B_RM_LO   = 31;

   localparam int unsigned INV_BITS  [N_INV]  = '{7, 8, 9, 10, 11, 12, 21, 22, 23};
   localparam int unsigned PAIR_FLAG [N_PAIR] = '{2, 3, 4, 5, 6};
   localparam int unsigned PAIR_EN   [N_PAIR] = '{24, 25, 26, 27, 28};

   function automatic int unsigned wpos(input int unsigned n);
      return FS_W - 1 - n;
   endfunction

   function automatic fs_word_t one_bit(input int unsigned n);
      fs_word_t m;
      m = '0;
      m[wpos(n)] = 1'b1;
      return m;
   endfunction

   function automatic fs_word_t build_inv_mask();
      fs_word_t m;
      m = '0;
      for (int k = 0; k < N_INV; k++) m[wpos(INV_BITS[k])] = 1'b1;
      return m;
   endfunction

   function automatic fs_word_t build_sticky_mask();
      fs_word_t m;
      m = build_inv_mask();
      for (int k = 1; k < N_PAIR; k++) m[wpos(PAIR_FLAG[k])] = 1'b1;
      return m;
   endfunction

   localparam fs_word_t INV_MASK    = build_inv_mask();
   localparam fs_word_t STICKY_MASK = build_sticky_mask();
   localparam fs_word_t SEEN_BIT    = one_bit(B_SEEN);
   localparam fs_word_t KEEP_MASK   = ~(one_bit(B_EN_SUM) | one_bit(B_INV_SUM) | one_bit(B_RSV));

endpackage

// File: rtl/fpu_stat_summ.sv
module fpu_stat_summ
   import fpu_stat_pkg::*;
#(
   parameter int unsigned PAIRS = N_PAIR
) (
   input  fs_word_t flags,
   output logic     inv_any,
   output logic     en_any
);

   logic [PAIRS-1:0] term;

   assign inv_any = |(flags & INV_MASK);

   generate
      for (genvar k = 0; k < PAIRS; k++) begin : g_pair
         if (PAIR_FLAG[k] == B_INV_SUM) begin : g_from_sum
            assign term[k] = inv_any & flags[wpos(PAIR_EN[k])];
         end else begin : g_from_flag
            assign term[k] = flags[wpos(PAIR_FLAG[k])] & flags[wpos(PAIR_EN[k])];
         end
      end
   endgenerate

   assign en_any = |term;

endmodule

// File: rtl/fpu_stat_next.sv
module fpu_stat_next
   import fpu_stat_pkg::*;
#(
   parameter int unsigned REG_W = FS_W,
   parameter int unsigned IDX_W = FS_IDX
) (
   input  fs_word_t         cur,
   input  logic             wr_en,
   input  fs_word_t         wr_data,
   input  logic             set_en,
   input  logic             clr_en,
   input  logic [IDX_W-1:0] bit_idx,
   input  logic             evt_en,
   input  fs_word_t         evt_flags,
   output fs_word_t         nxt
);

   fs_word_t sw_val;
   fs_word_t ev_val;
   fs_word_t rise;

   generate
      for (genvar w = 0; w < REG_W; w++) begin : g_bit
         localparam int unsigned BNUM = REG_W - 1 - w;
         logic hit;
         assign hit       = (bit_idx == IDX_W'(BNUM));
         assign sw_val[w] = wr_en           ? wr_data[w] :
                            (hit && clr_en) ? 1'b0       :
                            (hit && set_en) ? 1'b1       : cur[w];
      end
   endgenerate

   assign ev_val = (sw_val & KEEP_MASK) | (evt_en ? (evt_flags & STICKY_MASK) : '0);
   assign rise   = ev_val & ~cur & STICKY_MASK;
   assign nxt    = ev_val | ((|rise) ? SEEN_BIT : '0);

endmodule

// File: rtl/fpu_stat_reg.sv
module fpu_stat_reg
   import fpu_stat_pkg::*;
#(
   parameter int unsigned REG_W = 32,
   parameter int unsigned IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             set_en,
   input  logic             clr_en,
   input  logic [IDX_W-1:0] bit_idx,
   input  logic             evt_en,
   input  logic [REG_W-1:0] evt_flags,
   output logic [REG_W-1:0] stat_word,
   output logic [RM_W-1:0]  rmode,
   output logic             exc_irq
);

   generate
      if (REG_W != FS_W) begin : g_bad_width
         $error("fpu_stat_reg: REG_W must match the package word width");
      end
      if ((1 << IDX_W) != REG_W) begin : g_bad_index
         $error("fpu_stat_reg: IDX_W must address every bit of the word");
      end
   endgenerate

   fs_word_t q;
   fs_word_t nxt;
   logic     inv_any;
   logic     en_any;

   fpu_stat_next #(.REG_W(REG_W), .IDX_W(IDX_W)) u_next (
      .cur       (q),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .set_en    (set_en),
      .clr_en    (clr_en),
      .bit_idx   (bit_idx),
      .evt_en    (evt_en),
      .evt_flags (evt_flags),
      .nxt       (nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

   fpu_stat_summ #(.PAIRS(N_PAIR)) u_summ (
      .flags   (q),
      .inv_any (inv_any),
      .en_any  (en_any)
   );

   always_comb begin
      stat_word                   = q;
      stat_word[wpos(B_INV_SUM)]  = inv_any;
      stat_word[wpos(B_EN_SUM)]   = en_any;
   end

   assign rmode   = {q[wpos(B_RM_HI)], q[wpos(B_RM_LO)]};
   assign exc_irq = en_any;

   // R7
   seen_only_sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(q[wpos(B_SEEN)]) |-> $past(wr_en || clr_en));

   // R6
   evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_en |=> ((q & $past(evt_flags) & STICKY_MASK) == ($past(evt_flags) & STICKY_MASK)));

   // R5
   wr_plain_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((q & KEEP_MASK & ~STICKY_MASK & ~SEEN_BIT) ==
                 ($past(wr_data) & KEEP_MASK & ~STICKY_MASK & ~SEEN_BIT)));

   // R5
   clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !wr_en && !evt_en) |=> !q[REG_W - 1 - int'($past(bit_idx))]);

   // R8
   rmode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !((set_en || clr_en) && (int'(bit_idx) >= int'(B_RM_HI)))) |=> $stable(rmode));

   // R4
   inv_sum_not_settable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && !wr_en && !clr_en && !evt_en && (int'(bit_idx) == int'(B_INV_SUM)) &&
       ((q & INV_MASK) == '0)) |=> !stat_word[wpos(B_INV_SUM)]);

endmodule

// File: tb/fpu_stat_reg_tb.sv
module fpu_stat_reg_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        set_en = 1'b0;
   logic        clr_en = 1'b0;
   logic [4:0]  bit_idx = '0;
   logic        evt_en = 1'b0;
   logic [31:0] evt_flags = '0;
   logic [31:0] stat_word;
   logic [1:0]  rmode;
   logic        exc_irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [31:0] model = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fpu_stat_reg u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .set_en(set_en), .clr_en(clr_en), .bit_idx(bit_idx),
      .evt_en(evt_en), .evt_flags(evt_flags),
      .stat_word(stat_word), .rmode(rmode), .exc_irq(exc_irq)
   );

   function automatic logic [31:0] bn(input int n);
      return 32'h1 << (31 - n);
   endfunction

   function automatic logic [31:0] inv_set();
      return bn(7) | bn(8) | bn(9) | bn(10) | bn(11) | bn(12) | bn(21) | bn(22) | bn(23);
   endfunction

   function automatic logic [31:0] sticky_set();
      return inv_set() | bn(3) | bn(4) | bn(5) | bn(6);
   endfunction

   function automatic logic [31:0] ref_view(input logic [31:0] s);
      logic [31:0] v;
      logic inv;
      logic en;
      inv = (s & inv_set()) != 0;
      en  = (inv && (s & bn(24)) != 0) ||
            ((s & bn(3)) != 0 && (s & bn(25)) != 0) ||
            ((s & bn(4)) != 0 && (s & bn(26)) != 0) ||
            ((s & bn(5)) != 0 && (s & bn(27)) != 0) ||
            ((s & bn(6)) != 0 && (s & bn(28)) != 0);
      v = s & ~(bn(1) | bn(2) | bn(20));
      if (inv) v = v | bn(2);
      if (en)  v = v | bn(1);
      return v;
   endfunction

   function automatic logic [31:0] ref_next(input logic [31:0] cur, input logic w,
         input logic [31:0] wd, input logic st, input logic c, input int ix,
         input logic e, input logic [31:0] ef);
      logic [31:0] s;
      s = cur;
      if (w)       s = wd;
      else if (c)  s = s & ~bn(ix);
      else if (st) s = s | bn(ix);
      s = s & ~(bn(1) | bn(2) | bn(20));
      if (e) s = s | (ef & sticky_set());
      if ((s & ~cur & sticky_set()) != 0) s = s | bn(0);
      return s;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(input logic w, input logic [31:0] wd, input logic st, input logic c,
         input int ix, input logic e, input logic [31:0] ef, input string tag);
      logic [31:0] nx;
      logic [31:0] v;
      @(negedge clk);
      wr_en = w; wr_data = wd; set_en = st; clr_en = c;
      bit_idx = 5'(ix); evt_en = e; evt_flags = ef;
      nx = ref_next(model, w, wd, st, c, ix, e, ef);
      @(posedge clk);
      #1;
      model = nx;
      v = ref_view(model);
      chk(tag, stat_word, v);
      chk("R8", {30'd0, rmode}, {30'd0, model[1], model[0]});
      chk("R9", {31'd0, exc_irq}, {31'd0, v[30]});
   endtask

   task automatic do_wr(input logic [31:0] wd, input string tag);
      step(1'b1, wd, 1'b0, 1'b0, 0, 1'b0, '0, tag);
   endtask
   task automatic do_set(input int ix, input string tag);
      step(1'b0, '0, 1'b1, 1'b0, ix, 1'b0, '0, tag);
   endtask
   task automatic do_clr(input int ix, input string tag);
      step(1'b0, '0, 1'b0, 1'b1, ix, 1'b0, '0, tag);
   endtask
   task automatic do_evt(input logic [31:0] ef, input string tag);
      step(1'b0, '0, 1'b0, 1'b0, 0, 1'b1, ef, tag);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1", stat_word, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1", stat_word, 32'h0);
      chk("R1", {30'd0, rmode}, 32'h0);
      chk("R1", {31'd0, exc_irq}, 32'h0);

      // R5 sweep of every index: set then clear
      for (int ix = 0; ix < 32; ix++) begin
         do_wr(32'h0, "R5");
         do_set(ix, "R5");
         if (ix == 1 || ix == 2 || ix == 20) chk("R4", stat_word, 32'h0);
         do_clr(ix, "R5");
      end

      // R2 and R10: each invalid flag alone raises, then drops, the summary
      for (int k = 0; k < 9; k++) begin
         int b;
         b = (k < 6) ? (7 + k) : (15 + k);
         do_wr(32'h0, "R2");
         do_set(b, "R2");
         chk("R2", {31'd0, stat_word[29]}, 32'h1);
         do_clr(b, "R10");
         chk("R10", {31'd0, stat_word[29]}, 32'h0);
      end

      // R3 and R10: enabled-exception summary follows flag and enable pairs
      do_wr(32'h0, "R3");
      do_set(3, "R3");
      do_set(25, "R3");
      chk("R3", {31'd0, exc_irq}, 32'h1);
      do_clr(25, "R10");
      chk("R10", {31'd0, exc_irq}, 32'h0);
      do_set(25, "R3");
      do_clr(3, "R10");
      chk("R10", {31'd0, stat_word[30]}, 32'h0);
      do_set(9, "R3");
      do_set(24, "R3");
      chk("R3", {31'd0, exc_irq}, 32'h1);
      do_clr(9, "R10");
      chk("R10", stat_word & 32'h6000_0000, 32'h0);

      // R4: writes cannot force summaries or the reserved bit
      do_wr(32'h6000_0800, "R4");
      chk("R4", stat_word, 32'h0);
      do_wr(32'hFFFF_FFFF, "R4");
      chk("R4", stat_word, 32'hFFFF_F7FF);
      do_wr(32'h0, "R4");
      do_set(1, "R4");
      chk("R4", stat_word, 32'h0);

      // R5: same-cycle priority
      step(1'b0, '0, 1'b1, 1'b1, 7, 1'b0, '0, "R5");
      chk("R5", stat_word, 32'h0);
      do_set(7, "R5");
      step(1'b1, 32'h0000_0002, 1'b1, 1'b1, 31, 1'b0, '0, "R5");
      chk("R5", stat_word, 32'h0000_0002);

      // R6: event sets all sticky flags and leaves other bits alone
      do_wr(32'h0000_0003, "R6");
      do_evt(32'hFFFF_FFFF, "R6");
      chk("R6", stat_word, 32'hBFF8_0703);

      // R7: exception-seen bit only rises on new flags
      do_clr(0, "R7");
      chk("R7", {31'd0, stat_word[31]}, 32'h0);
      do_evt(32'hFFFF_FFFF, "R7");
      chk("R7", {31'd0, stat_word[31]}, 32'h0);
      do_clr(3, "R7");
      do_evt(bn(3), "R7");
      chk("R7", {31'd0, stat_word[31]}, 32'h1);

      // R6: event and clear of the same flag in one cycle
      do_wr(32'h0, "R6");
      step(1'b0, '0, 1'b0, 1'b1, 8, 1'b1, bn(8), "R6");
      chk("R6", stat_word, bn(0) | bn(2) | bn(8));

      // R8: rounding mode updates through clear and set
      do_wr(32'h0000_0002, "R8");
      do_clr(30, "R8");
      chk("R8", {30'd0, rmode}, 32'h0);
      do_set(31, "R8");
      chk("R8", {30'd0, rmode}, 32'h1);

      // random mix, compared every cycle (R2 R3 R9 R10)
      for (int n = 0; n < 4000; n++) begin
         int unsigned r;
         logic [31:0] wd;
         r  = $urandom;
         wd = ((r & 32'h30) == 0) ? 32'h0 : $urandom;
         step(r[2:0] == 3'd0, wd, r[3], r[4] & r[5], int'($urandom % 32),
              r[6] & r[7], $urandom & $urandom & $urandom, "R3");
      end

      @(negedge clk);
      wr_en = 1'b0; set_en = 1'b0; clr_en = 1'b0; evt_en = 1'b0;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule